// File: doc/BRIEF.md
# Gate Drive High-Frequency Chopper

This block sits between a PWM timing stage and the gate-drive pins of a three-phase inverter. Transformer-coupled gate drivers cannot pass a long steady level, so while a PWM signal is in its active state the block breaks it into a square-wave burst at a programmable frequency. Inactive PWM levels are never chopped.

A 10-bit configuration word is written through a single-cycle write strobe. It carries an 8-bit divider value N and one enable for each output group: the three high-side outputs and the three low-side outputs. The carrier period is 4×(N+1) clock cycles. With a 26 MHz clock this gives chop rates from about 25.4 kHz up to 6.5 MHz. A group whose enable is clear passes its PWM signals through. Every output is registered, so each output lags its input by one clock.

Top module: `gate_chopper`

## Requirements
- R1: After reset, all six outputs are at the inactive level (high), and the configuration word is all zeros, so neither group is chopped.
- R2: Bit 8 of the configuration word enables chopping of the three high-side outputs. It has no effect on the low-side outputs.
- R3: Bit 9 of the configuration word enables chopping of the three low-side outputs. It has no effect on the high-side outputs.
- R4: Bits 7:0 of the configuration word hold N. The carrier is a square wave with a period of 4×(N+1) clocks: 2×(N+1) clocks high, then 2×(N+1) clocks low.
- R5: A PWM input at its inactive level always gives an inactive output one clock later, whatever the configuration.
- R6: For a group whose enable bit is clear, each output equals its PWM input as sampled one clock earlier.
- R7: A configuration write restarts the carrier. The carrier begins a full high half-period of 2×(N+1) clocks, using the newly written N, in the cycle after the write.
- R8: The two extreme divider values behave as stated in R4: N=0 gives a period of 4 clocks, and N=255 gives a period of 1024 clocks.
- R9: Signals are active low (0 = active). A chopped output is 0 only when its PWM input was 0 and the carrier was high in the previous cycle. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe; also restarts the carrier |
| cfg_wdata_i | input | 10 | Configuration word: [9] low-side enable, [8] high-side enable, [7:0] divider N |
| pwm_hi_i | input | 3 | High-side PWM signals of phases 0 to 2, active low |
| pwm_lo_i | input | 3 | Low-side PWM signals of phases 0 to 2, active low |
| out_hi_o | output | 3 | High-side gate-drive outputs, registered |
| out_lo_o | output | 3 | Low-side gate-drive outputs, registered |

## Verification
The hardest case to reach from the ports is the interaction between carrier phase and configuration writes. A rewrite in the middle of a half-period must discard the old count. At N=255 a full period is more than a thousand clocks, so an off-by-one in the reload count only shows after a long steady run. The stimulus therefore holds PWM inputs active across many whole periods at N=0, N=2 and N=255, and rewrites the register in the middle of a half-period. The bench models the carrier from R4 and R7 alone and predicts every output cycle by cycle. Any phase slip or reload error therefore shows up as a mismatch on the chopped pins.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int DIV_W = 8;
  localparam int CFG_W = DIV_W + 2;

  typedef struct packed {
    logic             lo_en;
    logic             hi_en;
    logic [DIV_W-1:0] div;
  } chop_cfg_t;
endpackage

// File: rtl/chop_cfg_reg.sv
module chop_cfg_reg
  import chop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output chop_cfg_t        cfg_o
);
  chop_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (we_i) cfg_q <= chop_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/chop_carrier.sv
module chop_carrier
  import chop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] new_div_i,
  input  logic [DIV_W-1:0] cur_div_i,
  output logic             carrier_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             car_q;

  // half period minus one = 2N+1
  logic [CNT_W-1:0] reload_new, reload_cur;
  assign reload_new = {new_div_i, 1'b1};
  assign reload_cur = {cur_div_i, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
      car_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= reload_new;
      car_q <= 1'b1;
    end else if (cnt_q == '0) begin
      cnt_q <= reload_cur;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign carrier_o = car_q;
endmodule

// File: rtl/chop_gate.sv
module chop_gate #(
  parameter int NUM_CH     = 3,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              carrier_i,
  input  logic [NUM_CH-1:0] pwm_i,
  output logic [NUM_CH-1:0] out_o
);
  localparam logic ACT_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;

  logic [NUM_CH-1:0] nxt;
  logic [NUM_CH-1:0] out_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic act;
    assign act    = (pwm_i[i] == ACT_LVL) && (!en_i || carrier_i);
    assign nxt[i] = act ? ACT_LVL : ~ACT_LVL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= {NUM_CH{~ACT_LVL}};
    else         out_q <= nxt;
  end

  assign out_o = out_q;
endmodule

// File: rtl/gate_chopper.sv
module gate_chopper
  import chop_pkg::*;
#(
  parameter int NUM_PH     = 3,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [NUM_PH-1:0] pwm_hi_i,
  input  logic [NUM_PH-1:0] pwm_lo_i,
  output logic [NUM_PH-1:0] out_hi_o,
  output logic [NUM_PH-1:0] out_lo_o
);
  chop_cfg_t cfg;
  logic      carrier;

  chop_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  chop_carrier u_car (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_we_i),
    .new_div_i(cfg_wdata_i[DIV_W-1:0]),
    .cur_div_i(cfg.div),
    .carrier_o(carrier)
  );

  chop_gate #(.NUM_CH(NUM_PH), .ACTIVE_LOW(ACTIVE_LOW)) u_hi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg.hi_en),
    .carrier_i(carrier),
    .pwm_i    (pwm_hi_i),
    .out_o    (out_hi_o)
  );

  chop_gate #(.NUM_CH(NUM_PH), .ACTIVE_LOW(ACTIVE_LOW)) u_lo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg.lo_en),
    .carrier_i(carrier),
    .pwm_i    (pwm_lo_i),
    .out_o    (out_lo_o)
  );
endmodule

// File: rtl/chop_chk.sv
module chop_chk
  import chop_pkg::*;
#(
  parameter int NUM_PH     = 3,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [NUM_PH-1:0] pwm_hi_i,
  input logic [NUM_PH-1:0] pwm_lo_i,
  input logic [NUM_PH-1:0] out_hi_o,
  input logic [NUM_PH-1:0] out_lo_o,
  input logic              carrier_i
);
  localparam logic INACT = ACTIVE_LOW ? 1'b1 : 1'b0;
  localparam logic [NUM_PH-1:0] ALL_INACT = {NUM_PH{INACT}};

  // shadow of enables and divider, tracked from the write port
  logic             en_hi_q, en_lo_q, car_prev_q, valid_q;
  logic [DIV_W-1:0] n_q;
  logic [DIV_W+1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_hi_q <= 1'b0; en_lo_q <= 1'b0; n_q <= '0;
      car_prev_q <= 1'b1; valid_q <= 1'b0; run_q <= '0;
    end else begin
      if (cfg_we_i) begin
        en_hi_q <= cfg_wdata_i[DIV_W];
        en_lo_q <= cfg_wdata_i[DIV_W+1];
        n_q     <= cfg_wdata_i[DIV_W-1:0];
      end
      car_prev_q <= carrier_i;
      if (carrier_i != car_prev_q) run_q <= 1;
      else                         run_q <= run_q + 1'b1;
      if (cfg_we_i)                     valid_q <= 1'b0;
      else if (carrier_i != car_prev_q) valid_q <= 1'b1;
    end
  end

  logic [NUM_PH-1:0] idle_hi, idle_lo;
  assign idle_hi = ~(pwm_hi_i ^ ALL_INACT);
  assign idle_lo = ~(pwm_lo_i ^ ALL_INACT);

  assert_idle_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~(out_hi_o ^ ALL_INACT) & $past(idle_hi)) == $past(idle_hi)) &&
             ((~(out_lo_o ^ ALL_INACT) & $past(idle_lo)) == $past(idle_lo)));

  assert_bypass_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_hi_q && !cfg_we_i |=> out_hi_o == $past(pwm_hi_i));

  assert_bypass_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lo_q && !cfg_we_i |=> out_lo_o == $past(pwm_lo_i));

  assert_gap_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_hi_q && !cfg_we_i && !carrier_i |=> out_hi_o == ALL_INACT);

  assert_gap_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_lo_q && !cfg_we_i && !carrier_i |=> out_lo_o == ALL_INACT);

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> carrier_i);

  assert_half_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !cfg_we_i && (carrier_i != car_prev_q) |->
      run_q == ({2'b00, n_q} + 1'b1) * 2);
endmodule

bind gate_chopper chop_chk #(.NUM_PH(NUM_PH), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .pwm_hi_i   (pwm_hi_i),
  .pwm_lo_i   (pwm_lo_i),
  .out_hi_o   (out_hi_o),
  .out_lo_o   (out_lo_o),
  .carrier_i  (carrier)
);

// File: tb/tb_gate_chopper.sv
module tb_gate_chopper;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [2:0] pwm_hi = 3'b111, pwm_lo = 3'b111;
  logic [2:0] out_hi, out_lo;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gate_chopper dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo), .out_hi_o(out_hi), .out_lo_o(out_lo)
  );

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference model built from R4, R7, R9
  logic [9:0] cfg_m = '0;
  logic       car_m = 1'b1;
  logic [8:0] cnt_m = 9'd1;

  function automatic logic [2:0] gate(input logic [2:0] p, input logic en, input logic c);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = (p[i] == 1'b0 && (!en || c)) ? 1'b0 : 1'b1;
    return r;
  endfunction

  task automatic step(input logic we, input logic [9:0] d, input logic [2:0] hi,
                      input logic [2:0] lo, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_wdata = d; pwm_hi = hi; pwm_lo = lo;
    e.hi = gate(hi, cfg_m[8], car_m);
    e.lo = gate(lo, cfg_m[9], car_m);
    e.tag = tag;
    sb.push_back(e);
    if (we) begin
      cfg_m = d; car_m = 1'b1; cnt_m = {d[7:0], 1'b1};
    end else if (cnt_m == 0) begin
      cnt_m = {cfg_m[7:0], 1'b1}; car_m = ~car_m;
    end else begin
      cnt_m = cnt_m - 1'b1;
    end
  endtask

  task automatic run(input int n, input logic [2:0] hi, input logic [2:0] lo, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 10'd0, hi, lo, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (out_hi !== e.hi || out_lo !== e.lo) begin
          errors++;
          $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", e.tag, out_hi, out_lo, e.hi, e.lo);
        end
      end
    end
  end

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35;
    checks++;
    if (out_hi !== 3'b111 || out_lo !== 3'b111) begin
      errors++;
      $display("FAIL R1: reset hi=%b lo=%b expected 111 111", out_hi, out_lo);
    end
    @(negedge clk); rst_ni = 1'b1;
    // R1/R6: defaults leave both groups unchopped
    run(20, 3'b010, 3'b101, "R1");
    run(6, 3'b000, 3'b000, "R6");
    run(4, 3'b110, 3'b011, "R6");
    // R2/R4/R9: high side chopped, N=2, low side untouched
    step(1'b1, 10'h102, 3'b000, 3'b000, "R2");
    run(50, 3'b000, 3'b000, "R2 R4 R9");
    run(10, 3'b101, 3'b010, "R2");
    // R3/R8: low side only, N=0
    step(1'b1, 10'h200, 3'b000, 3'b000, "R3");
    run(30, 3'b000, 3'b000, "R3 R8");
    // R5: idle levels stay idle under chopping
    step(1'b1, 10'h301, 3'b111, 3'b111, "R5");
    run(20, 3'b111, 3'b111, "R5");
    run(20, 3'b011, 3'b110, "R5 R9");
    // R7: rewrite in the middle of a half-period
    step(1'b1, 10'h305, 3'b000, 3'b000, "R7");
    run(15, 3'b000, 3'b000, "R7");
    step(1'b1, 10'h303, 3'b000, 3'b000, "R7");
    run(40, 3'b000, 3'b000, "R7 R4");
    step(1'b1, 10'h303, 3'b000, 3'b000, "R7");
    run(3, 3'b000, 3'b000, "R7");
    // R8: largest divider across two full periods
    step(1'b1, 10'h3FF, 3'b000, 3'b000, "R8");
    run(2100, 3'b000, 3'b000, "R8 R4");
    // R6 again after turning both enables off
    step(1'b1, 10'h0FF, 3'b001, 3'b100, "R6");
    run(20, 3'b010, 3'b000, "R6");
    run(3, 3'b111, 3'b111, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule